// File: doc/BRIEF.md
# Calendar Shadow Read Lock

This block sits between the running calendar counters and the bus read path. It holds a time shadow and a date shadow. On every second tick of the slow timekeeping clock it copies the live counter values into both shadows and raises a sync flag. The flag tells software that the shadows hold a fresh, matching pair.

Software first reads the flag. It then reads the time shadow and the date shadow, in that order. A time read taken while the flag is set takes a lock, which freezes both shadows. The date read that follows therefore belongs to the same instant as the time just read. Software releases the lock by writing a flag-clear strobe. The shadows then resync after two more ticks.

Entering initialisation, or waking from low power, also drops the flag. The shadows are not trusted again until the next copy has landed. The calendar counting itself is outside this block.

Read accesses are single-cycle strobes with combinational data. They have no valid/ready handshake, because reads never stall and carry no back-pressure. All control and status pins are plain levels or one-cycle pulses.

Top module: `cal_shadow_lock`

## Requirements
- R1: After reset the sync flag is 0, both shadows read 0 and no lock is held.
- R2: After the flag has been cleared, the first tick changes nothing. On the second tick the time shadow takes `cal_time`, the date shadow takes `cal_date`, and the flag becomes 1, all at the same clock edge.
- R3: While no lock is held, the shadows copy the counters again on every second tick, whatever the value of the flag.
- R4: A read of address 0 (time) while the flag is 1 takes the lock. While the lock is held, neither shadow changes on any tick and the flag stays 1.
- R5: A one-cycle `flag_clr` pulse clears the flag and releases the lock. The next copy then follows R2.
- R6: While `init_mode` is 1 the flag is 0, any lock is released, and no copy happens. After `init_mode` falls, the copy follows R2.
- R7: A one-cycle `wake` pulse clears the flag. The next copy then follows R2.
- R8: Read map on `rd_addr`: 0 returns the time shadow, 1 returns the date shadow, and 2 returns the status word with the flag in bit 0 and zeros elsewhere. Address 3 returns 0. Shadows are zero-extended to the bus width.
- R9: A time read while the flag is 0 takes no lock. The copy still happens on the second tick.
- R10: A time read in the same cycle as a copying tick returns the old time shadow. It takes the lock, and the copy is suppressed.
- R11: A read of address 1 (date) never takes the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| rtc_tick | input | 1 | One-cycle pulse per slow-clock period |
| cal_time | input | TIME_W | Live time counter value |
| cal_date | input | DATE_W | Live date counter value |
| init_mode | input | 1 | Calendar initialisation level |
| wake | input | 1 | Low-power exit pulse |
| flag_clr | input | 1 | Software write clearing the sync flag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data, valid in the strobe cycle |
| sync_flag | output | 1 | Shadows valid |

## Verification
The bench checks that the first tick after a clear changes nothing. A design that copied on every tick would raise the flag one tick early. The bench changes the counters while the lock is held and reads the date shadow. A design with a leaky lock would return a date that does not match the frozen time. It also lands a time read on the copying tick. A design that let the copy win would hand back a time and a date from different instants. Finally, it checks that a time read while the flag is 0, or a date read at any time, takes no lock. A design that locked on these would stall the refresh until software cleared the flag.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  typedef enum logic [1:0] {
    ADDR_TIME = 2'd0,
    ADDR_DATE = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } shadow_addr_e;
endpackage

// File: rtl/shadow_tick_div.sv
module shadow_tick_div #(
  parameter int COPY_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic restart,
  output logic copy
);
  localparam int CW = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(COPY_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign copy = tick && enable && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick && enable) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/shadow_lock_ctrl.sv
module shadow_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic init_mode,
  input  logic wake,
  input  logic flag_clr,
  input  logic time_rd,
  input  logic copy,
  output logic sync_flag,
  output logic locked,
  output logic lock_req,
  output logic drop
);
  assign drop     = init_mode | wake | flag_clr;
  assign lock_req = time_rd && sync_flag && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_flag <= 1'b0;
      locked    <= 1'b0;
    end else begin
      if (drop) begin
        sync_flag <= 1'b0;
      end else if (copy) begin
        sync_flag <= 1'b1;
      end

      if (drop) begin
        locked <= 1'b0;
      end else if (lock_req) begin
        locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shadow_reg.sv
module shadow_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/cal_shadow_lock.sv
module cal_shadow_lock
  import cal_shadow_pkg::*;
#(
  parameter int TIME_W     = 24,
  parameter int DATE_W     = 24,
  parameter int DATA_W     = 32,
  parameter int COPY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic [TIME_W-1:0] cal_time,
  input  logic [DATE_W-1:0] cal_date,
  input  logic              init_mode,
  input  logic              wake,
  input  logic              flag_clr,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sync_flag
);
  logic              time_rd;
  logic              locked;
  logic              lock_req;
  logic              drop;
  logic              copy;
  logic              div_en;
  logic [TIME_W-1:0] time_sh;
  logic [DATE_W-1:0] date_sh;

  assign time_rd = rd_en && (shadow_addr_e'(rd_addr) == ADDR_TIME);
  assign div_en  = !locked && !lock_req && !init_mode;

  shadow_tick_div #(.COPY_TICKS(COPY_TICKS)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (rtc_tick),
    .enable  (div_en),
    .restart (drop),
    .copy    (copy)
  );

  shadow_lock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_mode (init_mode),
    .wake      (wake),
    .flag_clr  (flag_clr),
    .time_rd   (time_rd),
    .copy      (copy),
    .sync_flag (sync_flag),
    .locked    (locked),
    .lock_req  (lock_req),
    .drop      (drop)
  );

  shadow_reg #(.W(TIME_W)) u_time (
    .clk (clk), .rst_n (rst_n), .load (copy), .d (cal_time), .q (time_sh)
  );

  shadow_reg #(.W(DATE_W)) u_date (
    .clk (clk), .rst_n (rst_n), .load (copy), .d (cal_date), .q (date_sh)
  );

  always_comb begin
    rd_data = '0;
    unique case (shadow_addr_e'(rd_addr))
      ADDR_TIME: rd_data[TIME_W-1:0] = time_sh;
      ADDR_DATE: rd_data[DATE_W-1:0] = date_sh;
      ADDR_STAT: rd_data[0]          = sync_flag;
      default:   rd_data             = '0;
    endcase
  end
endmodule

// File: rtl/cal_shadow_lock_chk.sv
module cal_shadow_lock_chk #(
  parameter int TIME_W = 24,
  parameter int DATE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rtc_tick,
  input logic              init_mode,
  input logic              wake,
  input logic              flag_clr,
  input logic              sync_flag,
  input logic              locked,
  input logic [TIME_W-1:0] time_sh,
  input logic [DATE_W-1:0] date_sh
);
  AST_FLAG_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> $past(rtc_tick)); // R2

  AST_LOCK_FREEZES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !init_mode && !wake && !flag_clr) |=> $stable(time_sh)); // R4

  AST_LOCK_FREEZES_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !init_mode && !wake && !flag_clr) |=> $stable(date_sh)); // R4

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!sync_flag && !locked)); // R5

  AST_INIT_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> (!sync_flag && !locked)); // R6

  AST_WAKE_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !sync_flag); // R7
endmodule

bind cal_shadow_lock cal_shadow_lock_chk #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rtc_tick  (rtc_tick),
  .init_mode (init_mode),
  .wake      (wake),
  .flag_clr  (flag_clr),
  .sync_flag (sync_flag),
  .locked    (locked),
  .time_sh   (time_sh),
  .date_sh   (date_sh)
);

// File: tb/cal_shadow_lock_test.sv
module cal_shadow_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 24;
  localparam int DW = 24;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rtc_tick = 1'b0;
  logic [TW-1:0] cal_time = '0;
  logic [DW-1:0] cal_date = '0;
  logic          init_mode = 1'b0;
  logic          wake = 1'b0;
  logic          flag_clr = 1'b0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = 2'd0;
  logic [BW-1:0] rd_data;
  logic          sync_flag;

  int checks = 0;
  int errors = 0;
  logic [BW-1:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_shadow_lock uut (
    .clk (clk), .rst_n (rst_n), .rtc_tick (rtc_tick),
    .cal_time (cal_time), .cal_date (cal_date),
    .init_mode (init_mode), .wake (wake), .flag_clr (flag_clr),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
    .sync_flag (sync_flag)
  );

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [BW-1:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    rd(2'd2, v); check("R1 status", v, 0);
    rd(2'd1, v); check("R1 date", v, 0);
    rd(2'd0, v); check("R1 time", v, 0);
  endtask

  task automatic t_first_copy();
    cal_time = 24'h123456; cal_date = 24'h250101;
    tick();
    rd(2'd2, v); check("R2 first tick", v, 0);
    tick();
    rd(2'd2, v); check("R2 flag set", v, 1);
    rd(2'd1, v); check("R2 date copied", v, 32'h250101);
    rd(2'd0, v); check("R2 time copied", v, 32'h123456);
  endtask

  task automatic t_lock();
    cal_time = 24'h000111; cal_date = 24'h990909;
    tick(); tick(); tick();
    rd(2'd1, v); check("R4 date frozen", v, 32'h250101);
    rd(2'd0, v); check("R4 time frozen", v, 32'h123456);
    rd(2'd2, v); check("R4 flag held", v, 1);
  endtask

  task automatic t_release();
    clr();
    rd(2'd2, v); check("R5 flag cleared", v, 0);
    tick();
    rd(2'd2, v); check("R5 first tick", v, 0);
    tick();
    rd(2'd2, v); check("R5 flag back", v, 1);
    rd(2'd1, v); check("R5 date after release", v, 32'h990909);
  endtask

  task automatic t_date_no_lock();
    cal_time = 24'h000222; cal_date = 24'h880808;
    tick(); tick();
    rd(2'd1, v); check("R11 date fresh", v, 32'h880808);
    cal_date = 24'h770707;
    tick(); tick();
    rd(2'd1, v); check("R11 R3 refresh continues", v, 32'h770707);
  endtask

  task automatic t_time_no_flag();
    clr();
    rd(2'd0, v);
    cal_time = 24'h000333; cal_date = 24'h660606;
    tick(); tick();
    rd(2'd2, v); check("R9 flag set", v, 1);
    rd(2'd1, v); check("R9 date copied", v, 32'h660606);
  endtask

  task automatic t_same_cycle();
    tick();
    cal_time = 24'h000444; cal_date = 24'h550505;
    @(negedge clk); rtc_tick = 1'b1; rd_en = 1'b1; rd_addr = 2'd0;
    #1 v = rd_data;
    @(negedge clk); rtc_tick = 1'b0; rd_en = 1'b0;
    check("R10 old time", v, 32'h000333);
    rd(2'd1, v); check("R10 copy suppressed", v, 32'h660606);
    tick(); tick();
    rd(2'd1, v); check("R10 lock held", v, 32'h660606);
  endtask

  task automatic t_init();
    @(negedge clk); init_mode = 1'b1;
    rd(2'd2, v); check("R6 flag dropped", v, 0);
    tick(); tick(); tick();
    rd(2'd2, v); check("R6 no copy in init", v, 0);
    @(negedge clk); init_mode = 1'b0;
    tick();
    rd(2'd2, v); check("R6 first tick", v, 0);
    tick();
    rd(2'd2, v); check("R6 flag after init", v, 1);
    rd(2'd1, v); check("R6 lock released", v, 32'h550505);
  endtask

  task automatic t_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    rd(2'd2, v); check("R7 flag dropped", v, 0);
    tick();
    rd(2'd2, v); check("R7 first tick", v, 0);
    tick();
    rd(2'd2, v); check("R7 flag back", v, 1);
  endtask

  task automatic t_map();
    rd(2'd3, v); check("R8 unused address", v, 0);
    rd(2'd2, v); check("R8 status upper bits", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_copy();
    t_lock();
    t_release();
    t_date_no_lock();
    t_time_no_flag();
    t_same_cycle();
    t_init();
    t_wake();
    t_map();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule